// File: doc/BRIEF.md
# Key Frame Ghost and Layer Filter

This block sits behind a keyboard matrix scanner. Once per scan frame it takes a snapshot of up to eight pressed-key scan codes and turns it into a stream of press and release events. Each scan code carries a row number in its upper bits and a column number in its lower bits. One configurable code can act as a layer-select key. When layer mode is on and that key is held, the key itself is dropped from the frame and every other code is moved into a second keymap layer by adding the keymap size.

After the layer step the block can test the frame for the ghosting pattern of a passive key matrix. If the pattern is found, the whole frame is thrown away. An accepted frame is compared with the last accepted frame. First, one release event is emitted for each previously held key that is now missing. Then one press event is emitted for each key in the new frame. Events leave one per handshake, and a one-cycle frame-done strobe marks the end of each frame's processing. An empty frame therefore releases every held key.

Top module: `kf_frame_filter`

## Requirements
- R1: Entry i of `in_codes` occupies bits [7i+6:7i]. Within an entry, bits [6:3] are the row and bits [2:0] are the column, so code = row*8 + column. Only the first min(`in_count`, 8) entries are used, and counts of 9 to 15 act as 8.
- R2: A frame is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while no frame is in progress. After reset, `in_ready` is 1, `ev_valid` is 0, `frame_done` is 0, and the stored frame is empty.
- R3: When `layer_en` is 1 and a used entry equals `fn_code`, every such entry is removed. Each remaining code then gets 128 added, which sets bit 7 of `ev_code`.
- R4: When `layer_en` is 0, an entry equal to `fn_code` is an ordinary key, and event codes stay in the range 0 to 127.
- R5: A frame is rejected when all of the following hold: `ghost_en` is 1; at least three keys remain after layer-key removal; some pair of the remaining keys shares a column; and some pair shares a row. A rejected frame emits no events and leaves the stored frame unchanged, so the next frame is compared with the last accepted one.
- R6: No frame is rejected when `ghost_en` is 0, or when fewer than three keys remain, or when only rows (or only columns) are shared.
- R7: For an accepted frame, each stored key whose 8-bit code is absent from the new frame gets a release event (`ev_press` = 0). These events come in stored order, and all of them come before any press event.
- R8: For an accepted frame, each key of the new frame gets a press event (`ev_press` = 1) in frame order, including keys that were already held. The new frame then becomes the stored frame.
- R9: A frame with zero keys releases every stored key and leaves the stored frame empty.
- R10: An event is transferred on each rising edge where `ev_valid` and `ev_ready` are both high. While `ev_valid` is high and `ev_ready` is low, `ev_code` and `ev_press` hold their values.
- R11: `frame_done` pulses high for exactly one cycle after the last event of every frame taken in, including rejected frames. It is never high together with `ev_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Frame offered |
| in_ready | output | 1 | Block idle, frame can be taken |
| in_codes | input | 56 | Eight 7-bit scan codes, entry 0 in the lowest bits |
| in_count | input | 4 | Number of used entries |
| ghost_en | input | 1 | Enable ghost-pattern rejection |
| layer_en | input | 1 | Enable layer-key removal and code offset |
| fn_code | input | 7 | Scan code of the layer-select key |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer takes the event |
| ev_code | output | 8 | Event code, bit 7 set for the second layer |
| ev_press | output | 1 | 1 for press, 0 for release |
| frame_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench builds the block with its default parameters: eight entries, a 4-bit row and a 3-bit column. This puts full eight-key frames, the bit-7 layer offset and over-range counts up to 15 all within reach of the 4-bit count port. Random frames drawn from a dense 3x3 corner of the matrix make ghost patterns and held keys common. Directed frames cover the remaining cases: the layer key removing a would-be ghost, only rows shared, empty frames, and a long stall on the event output.

// File: rtl/kf_pkg.sv
package kf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REL  = 2'd1,
    ST_PRS  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/kf_layer_compact.sv
// Drops the layer-select key when layer mode is on, packs the remaining
// codes to the front and appends the layer bit to each of them.
module kf_layer_compact #(
  parameter int MAX_KEYS = 8,
  parameter int CODE_W   = 7,
  parameter int CNT_W    = 4,
  localparam int EV_W    = CODE_W + 1
) (
  input  logic [MAX_KEYS*CODE_W-1:0] codes_i,
  input  logic [CNT_W-1:0]           count_i,
  input  logic                       layer_en_i,
  input  logic [CODE_W-1:0]          fn_code_i,
  output logic [MAX_KEYS*CODE_W-1:0] raw_o,
  output logic [MAX_KEYS*EV_W-1:0]   ev_o,
  output logic [CNT_W-1:0]           count_o
);

  logic [CNT_W-1:0]  eff_cnt;
  logic [CODE_W-1:0] code;
  logic              fn_seen;

  always_comb begin
    int n;
    n       = 0;
    fn_seen = 1'b0;
    raw_o   = '0;
    code    = '0;
    eff_cnt = (count_i > CNT_W'(MAX_KEYS)) ? CNT_W'(MAX_KEYS) : count_i;
    for (int i = 0; i < MAX_KEYS; i++) begin
      code = codes_i[i*CODE_W +: CODE_W];
      if (CNT_W'(i) < eff_cnt) begin
        if (layer_en_i && (code == fn_code_i)) begin
          fn_seen = 1'b1;
        end else begin
          raw_o[n*CODE_W +: CODE_W] = code;
          n = n + 1;
        end
      end
    end
    count_o = CNT_W'(n);
    for (int k = 0; k < MAX_KEYS; k++) begin
      ev_o[k*EV_W +: EV_W] = {fn_seen, raw_o[k*CODE_W +: CODE_W]};
    end
  end

endmodule

// File: rtl/kf_ghost_detect.sv
// Pairwise row/column sharing test over the packed key list.
module kf_ghost_detect #(
  parameter int MAX_KEYS = 8,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 3,
  parameter int CNT_W    = 4,
  localparam int CODE_W  = ROW_W + COL_W
) (
  input  logic [MAX_KEYS*CODE_W-1:0] raw_i,
  input  logic [CNT_W-1:0]           count_i,
  input  logic                       enable_i,
  output logic                       ghost_o
);

  logic shared_col;
  logic shared_row;

  always_comb begin
    shared_col = 1'b0;
    shared_row = 1'b0;
    for (int i = 0; i < MAX_KEYS; i++) begin
      for (int j = i + 1; j < MAX_KEYS; j++) begin
        if (CNT_W'(j) < count_i) begin
          if (raw_i[i*CODE_W +: COL_W] == raw_i[j*CODE_W +: COL_W])
            shared_col = 1'b1;
          if (raw_i[i*CODE_W+COL_W +: ROW_W] == raw_i[j*CODE_W+COL_W +: ROW_W])
            shared_row = 1'b1;
        end
      end
    end
    ghost_o = enable_i && (count_i >= CNT_W'(3)) && shared_col && shared_row;
  end

endmodule

// File: rtl/kf_event_seq.sv
// Holds the last accepted frame, sequences release then press events.
module kf_event_seq
  import kf_pkg::*;
#(
  parameter int MAX_KEYS = 8,
  parameter int EV_W     = 8,
  parameter int CNT_W    = 4,
  parameter int IDX_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [MAX_KEYS*EV_W-1:0] codes_i,
  input  logic [CNT_W-1:0]         count_i,
  input  logic                     reject_i,
  output logic                     ev_valid_o,
  input  logic                     ev_ready_i,
  output logic [EV_W-1:0]          ev_code_o,
  output logic                     ev_press_o,
  output logic                     done_o
);

  seq_state_e              state_q, state_d;
  logic [MAX_KEYS*EV_W-1:0] cur_q, prev_q;
  logic [CNT_W-1:0]         cur_cnt_q, prev_cnt_q;
  logic [MAX_KEYS-1:0]      rel_q, rel_d, miss;
  logic [CNT_W-1:0]         idx_q, idx_d;
  logic                     keep_q, keep_d;
  logic                     cap_en, commit_en, take, fire;
  logic [IDX_W-1:0]         sel_idx;
  logic [EV_W-1:0]          sel_code;

  assign take       = in_valid_i && (state_q == ST_IDLE);
  assign in_ready_o = (state_q == ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  // Stored keys missing from the incoming frame.
  always_comb begin
    logic hit;
    for (int i = 0; i < MAX_KEYS; i++) begin
      hit = 1'b0;
      for (int k = 0; k < MAX_KEYS; k++) begin
        if ((CNT_W'(k) < count_i) &&
            (codes_i[k*EV_W +: EV_W] == prev_q[i*EV_W +: EV_W]))
          hit = 1'b1;
      end
      miss[i] = (CNT_W'(i) < prev_cnt_q) && !hit;
    end
  end

  // Lowest pending release wins.
  always_comb begin
    sel_idx = '0;
    for (int i = MAX_KEYS - 1; i >= 0; i--) begin
      if (rel_q[i]) sel_idx = IDX_W'(i);
    end
  end
  assign sel_code = prev_q[sel_idx*EV_W +: EV_W];

  always_comb begin
    ev_valid_o = ((state_q == ST_REL) && (|rel_q)) ||
                 ((state_q == ST_PRS) && (idx_q < cur_cnt_q));
    ev_press_o = (state_q == ST_PRS);
    ev_code_o  = (state_q == ST_REL) ? sel_code
                                     : cur_q[idx_q[IDX_W-1:0]*EV_W +: EV_W];
  end
  assign fire = ev_valid_o && ev_ready_i;

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    rel_d     = rel_q;
    idx_d     = idx_q;
    keep_d    = keep_q;
    cap_en    = 1'b0;
    commit_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take) begin
          cap_en  = !reject_i;
          keep_d  = !reject_i;
          idx_d   = '0;
          rel_d   = reject_i ? '0 : miss;
          state_d = reject_i ? ST_DONE : ST_REL;
        end
      end
      ST_REL: begin
        if (|rel_q) begin
          if (fire) rel_d = rel_q & ~(MAX_KEYS'(1) << sel_idx);
        end else begin
          idx_d   = '0;
          state_d = ST_PRS;
        end
      end
      ST_PRS: begin
        if (idx_q < cur_cnt_q) begin
          if (fire) idx_d = idx_q + CNT_W'(1);
        end else begin
          state_d = ST_DONE;
        end
      end
      default: begin
        commit_en = keep_q;
        state_d   = ST_IDLE;
      end
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rel_q      <= '0;
      idx_q      <= '0;
      keep_q     <= 1'b0;
      cur_q      <= '0;
      cur_cnt_q  <= '0;
      prev_q     <= '0;
      prev_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      rel_q   <= rel_d;
      idx_q   <= idx_d;
      keep_q  <= keep_d;
      if (cap_en) begin
        cur_q     <= codes_i;
        cur_cnt_q <= count_i;
      end
      if (commit_en) begin
        prev_q     <= cur_q;
        prev_cnt_q <= cur_cnt_q;
      end
    end
  end

endmodule

// File: rtl/kf_frame_filter.sv
module kf_frame_filter #(
  parameter int MAX_KEYS = 8,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 3,
  localparam int CODE_W  = ROW_W + COL_W,
  localparam int EV_W    = CODE_W + 1,
  localparam int CNT_W   = $clog2(MAX_KEYS + 1),
  localparam int IDX_W   = $clog2(MAX_KEYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [MAX_KEYS*CODE_W-1:0] in_codes,
  input  logic [CNT_W-1:0]           in_count,
  input  logic                       ghost_en,
  input  logic                       layer_en,
  input  logic [CODE_W-1:0]          fn_code,
  output logic                       ev_valid,
  input  logic                       ev_ready,
  output logic [EV_W-1:0]            ev_code,
  output logic                       ev_press,
  output logic                       frame_done
);

  logic [1:0]                 rst_sync_q;
  logic                       rst_int_n;
  logic [MAX_KEYS*CODE_W-1:0] raw_codes;
  logic [MAX_KEYS*EV_W-1:0]   layer_codes;
  logic [CNT_W-1:0]           kept_cnt;
  logic                       ghost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  kf_layer_compact #(
    .MAX_KEYS(MAX_KEYS), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) u_compact (
    .codes_i   (in_codes),
    .count_i   (in_count),
    .layer_en_i(layer_en),
    .fn_code_i (fn_code),
    .raw_o     (raw_codes),
    .ev_o      (layer_codes),
    .count_o   (kept_cnt)
  );

  kf_ghost_detect #(
    .MAX_KEYS(MAX_KEYS), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)
  ) u_ghost (
    .raw_i   (raw_codes),
    .count_i (kept_cnt),
    .enable_i(ghost_en),
    .ghost_o (ghost)
  );

  kf_event_seq #(
    .MAX_KEYS(MAX_KEYS), .EV_W(EV_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid_i(in_valid),
    .in_ready_o(in_ready),
    .codes_i   (layer_codes),
    .count_i   (kept_cnt),
    .reject_i  (ghost),
    .ev_valid_o(ev_valid),
    .ev_ready_i(ev_ready),
    .ev_code_o (ev_code),
    .ev_press_o(ev_press),
    .done_o    (frame_done)
  );

endmodule

// File: rtl/kf_frame_checker.sv
module kf_frame_checker #(
  parameter int EV_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            ev_valid,
  input logic            ev_ready,
  input logic [EV_W-1:0] ev_code,
  input logic            ev_press,
  input logic            frame_done
);

  logic press_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             press_seen_q <= 1'b0;
    else if (frame_done)                    press_seen_q <= 1'b0;
    else if (ev_valid && ev_ready && ev_press) press_seen_q <= 1'b1;
  end

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_press));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !ev_valid && !frame_done);

  assert_done_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !ev_valid);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done && in_ready);

  assert_release_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    press_seen_q |-> !(ev_valid && !ev_press));

endmodule

bind kf_frame_filter kf_frame_checker #(.EV_W(EV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_code   (ev_code),
  .ev_press  (ev_press),
  .frame_done(frame_done)
);

// File: tb/kf_frame_filter_tb.sv
module kf_frame_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [55:0] in_codes;
  logic [3:0]  in_count;
  logic        ghost_en;
  logic        layer_en;
  logic [6:0]  fn_code;
  logic        ev_valid;
  logic        ev_ready;
  logic [7:0]  ev_code;
  logic        ev_press;
  logic        frame_done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int f_codes[8];
  int prev_c[8];
  int prev_n = 0;

  always #4 clk = ~clk;

  kf_frame_filter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_codes(in_codes), .in_count(in_count), .ghost_en(ghost_en),
    .layer_en(layer_en), .fn_code(fn_code), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_code(ev_code), .ev_press(ev_press),
    .frame_done(frame_done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      n_chk  = n_chk + 1;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_frame(input string tag, input int cnt, input bit g,
                           input bit l, input int fn, input bit stall);
    int eff, n, en, rn, waitc;
    int raw[8];
    int newc[8];
    int ec[24];
    int ep[24];
    int rc[32];
    int rp[32];
    bit fs, sc, sr, rej, hit, pend;
    int last_code;
    // expected result from the requirements
    eff = (cnt > 8) ? 8 : cnt;
    n = 0; fs = 0;
    for (int i = 0; i < eff; i++) begin
      if (l && f_codes[i] == fn) fs = 1;
      else begin raw[n] = f_codes[i]; n++; end
    end
    sc = 0; sr = 0;
    for (int i = 0; i < n; i++)
      for (int j = i + 1; j < n; j++) begin
        if ((raw[i] & 7) == (raw[j] & 7)) sc = 1;
        if ((raw[i] >> 3) == (raw[j] >> 3)) sr = 1;
      end
    rej = g && (n >= 3) && sc && sr;
    for (int i = 0; i < n; i++) newc[i] = raw[i] + (fs ? 128 : 0);
    en = 0;
    if (!rej) begin
      for (int i = 0; i < prev_n; i++) begin
        hit = 0;
        for (int k = 0; k < n; k++) if (newc[k] == prev_c[i]) hit = 1;
        if (!hit) begin ec[en] = prev_c[i]; ep[en] = 0; en++; end
      end
      for (int k = 0; k < n; k++) begin ec[en] = newc[k]; ep[en] = 1; en++; end
    end
    // drive the frame
    for (int i = 0; i < 8; i++) in_codes[i*7 +: 7] = 7'(f_codes[i]);
    in_count = 4'(cnt);
    ghost_en = g;
    layer_en = l;
    fn_code  = 7'(fn);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // collect events
    rn = 0; pend = 0; waitc = 0; last_code = 0;
    forever begin
      if (pend)
        check(ev_valid === 1'b1 && int'(ev_code) == last_code, "R10",
              "stalled event held", int'(ev_code), last_code);
      ev_ready = (stall && waitc < 5) ? 1'b0 : 1'($urandom % 2);
      waitc++;
      pend = 0;
      if (ev_valid) begin
        if (ev_ready) begin
          if (rn < 32) begin rc[rn] = int'(ev_code); rp[rn] = int'(ev_press); end
          rn++;
        end else begin
          pend = 1;
          last_code = int'(ev_code);
        end
      end
      if (frame_done) break;
      @(negedge clk);
    end
    ev_ready = 1'b0;
    @(negedge clk);
    check(frame_done == 1'b0 && in_ready == 1'b1, "R11", "done pulse width",
          int'(frame_done), 0);
    check(rn == en, tag, "event count", rn, en);
    for (int k = 0; k < en && k < rn; k++)
      check(rc[k] == ec[k] && rp[k] == ep[k], tag,
            ep[k] ? "press event R8" : "release event R7",
            rc[k] * 2 + rp[k], ec[k] * 2 + ep[k]);
    if (!rej) begin
      for (int i = 0; i < n; i++) prev_c[i] = newc[i];
      prev_n = n;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_codes = '0;
    in_count = '0;
    ghost_en = 1'b0;
    layer_en = 1'b0;
    fn_code  = '0;
    ev_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R2", "reset in_ready", int'(in_ready), 1);
    check(ev_valid == 1'b0, "R2", "reset ev_valid", int'(ev_valid), 0);
    check(frame_done == 1'b0, "R2", "reset frame_done", int'(frame_done), 0);

    // R8: first presses from an empty store
    f_codes = '{1, 19, 0, 0, 0, 0, 0, 0};
    run_frame("R8", 2, 1, 0, 0, 0);
    // R7: one held, one released, one new
    f_codes = '{19, 40, 0, 0, 0, 0, 0, 0};
    run_frame("R7", 2, 1, 0, 0, 0);
    // R5: ghost triangle rejected, store kept
    f_codes = '{9, 10, 17, 0, 0, 0, 0, 0};
    run_frame("R5", 3, 1, 0, 0, 0);
    f_codes = '{40, 0, 0, 0, 0, 0, 0, 0};
    run_frame("R5", 1, 1, 0, 0, 0);
    // R6: same triangle, filter off; rows only; two keys
    f_codes = '{9, 10, 17, 0, 0, 0, 0, 0};
    run_frame("R6", 3, 0, 0, 0, 0);
    f_codes = '{9, 10, 11, 0, 0, 0, 0, 0};
    run_frame("R6", 3, 1, 0, 0, 0);
    f_codes = '{9, 17, 0, 0, 0, 0, 0, 0};
    run_frame("R6", 2, 1, 0, 0, 0);
    // R3: layer key removed before the ghost test, offset applied
    f_codes = '{9, 10, 17, 10, 0, 0, 0, 0};
    run_frame("R3", 4, 1, 1, 10, 0);
    // R4: layer disabled, same code is a plain key
    f_codes = '{9, 10, 0, 0, 0, 0, 0, 0};
    run_frame("R4", 2, 1, 0, 10, 0);
    // R1: count above eight, and entries past the count ignored
    f_codes = '{0, 9, 18, 27, 36, 45, 54, 63};
    run_frame("R1", 12, 0, 0, 0, 0);
    f_codes = '{5, 100, 18, 27, 36, 45, 54, 63};
    run_frame("R1", 2, 0, 0, 0, 0);
    // R9: empty frames
    run_frame("R9", 0, 1, 0, 0, 0);
    run_frame("R9", 0, 1, 0, 0, 0);
    // R10: long stall on the output
    f_codes = '{3, 33, 66, 99, 0, 0, 0, 0};
    run_frame("R10", 4, 0, 0, 0, 1);

    for (int t = 0; t < 300; t++) begin
      bit dense, g, l, st;
      int cnt, fn;
      dense = 1'($urandom % 2);
      cnt   = int'($urandom % 11);
      g     = ($urandom % 4) != 0;
      l     = 1'($urandom % 2);
      st    = ($urandom % 8) == 0;
      for (int i = 0; i < 8; i++)
        f_codes[i] = dense ? int'(($urandom % 3) * 8 + ($urandom % 3))
                           : int'($urandom % 128);
      fn = dense ? int'(($urandom % 3) * 8 + ($urandom % 3)) : int'($urandom % 128);
      if (l && ($urandom % 2 == 0)) f_codes[$urandom % 8] = fn;
      run_frame("R7/R8", cnt, g, l, fn, st);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule